// File: doc/BRIEF.md
# Miss-Tolerant Pipeline Mode Controller

This controller lets an in-order pipeline keep running past a data-cache miss. In normal operation instructions simply execute. The first load that misses triggers three actions: a register-file checkpoint is taken, the controller enters advance mode, and the load is parked in an in-order slice queue. While advancing, one taint bit per architectural register follows the data dependences. An instruction that reads a tainted register is parked and taints its own destination. An instruction whose sources are all clean executes and keeps its result.

When the miss data returns, fetch is held and the instructions still in flight are drained. The parked instructions are then replayed in their original order. Fetch is released as soon as the queue is empty. The checkpoint is freed, and normal operation resumes, once the pipeline reports that the last replayed instruction has left. Two cases instead restore the checkpoint: a mispredict or exception during replay, and the queue or store buffer running out of room while advancing. In the second case the controller degrades to plain runahead, keeping no results, and the restore happens at the end of the drain.

Top module: `mtp_mode_ctrl`

## Requirements
- R1: In normal mode (`mode_o`=0), a valid instruction flagged as a missing load asserts `ckpt_take_o` and `defer_o` in that cycle, taints its destination, and moves the mode to advance (1) on the next cycle. Any other valid instruction asserts `exec_o`.
- R2: In advance or drain mode, a valid instruction that reads a tainted register asserts `defer_o` and not `exec_o`, and taints its destination.
- R3: In advance or drain mode, a valid instruction with no tainted source asserts `exec_o` and clears the taint of its destination.
- R4: `miss_ret_i` in advance mode moves the mode to drain (2), which holds `fetch_stall_o` high. Instructions arriving during drain are still classified by R2 and R3. `pipe_empty_i` during drain moves the mode to rally (3).
- R5: In rally mode, parked entries are presented on the `rally_*` outputs one per cycle, in the order they were parked, with `rally_valid_o` high. `fetch_stall_o` stays high only while entries remain.
- R6: In rally mode, an empty queue together with `pipe_empty_i` asserts `ckpt_release_o`, clears all taint bits and returns to normal mode.
- R7: `flush_i` during rally asserts `ckpt_restore_o`, `squash_o` and `sb_discard_o` together, suppresses `rally_valid_o`, empties the queue, clears all taint and returns to normal mode.
- R8: In advance or drain mode, `sb_full_i`, or a tainted instruction that meets a full queue, sets `fallback_o`. From then on nothing is parked, and the end of the drain restores the checkpoint as in R7 instead of entering rally.
- R9: The queue holds `SLICE_DEPTH` (default 128) entries. The 128th parked instruction is accepted and the 129th sets `fallback_o`.
- R10: A second missing load in advance mode does not assert `ckpt_take_o`. It is treated as a tainted instruction under R2.
- R11: The mode encoding is normal=0, advance=1, drain=2, rally=3. Reset gives normal mode, with `fallback_o`, `fetch_stall_o`, `rally_valid_o` and every checkpoint strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | An instruction is presented this cycle |
| insn_miss_i | input | 1 | The presented instruction is a load that missed |
| insn_cls_i | input | CLS_W | Opcode class |
| insn_rs1_i | input | REG_W | First source register |
| insn_rs2_i | input | REG_W | Second source register |
| insn_rd_i | input | REG_W | Destination register |
| insn_wr_i | input | 1 | The instruction writes its destination |
| insn_opv_i | input | OPV_W | Operand value already available |
| miss_ret_i | input | 1 | The miss being tolerated has returned |
| pipe_empty_i | input | 1 | No instruction is in flight |
| sb_full_i | input | 1 | Store buffer is full |
| flush_i | input | 1 | Mispredict or exception seen during rally |
| mode_o | output | 2 | Current mode |
| fallback_o | output | 1 | Runahead fallback active |
| exec_o | output | 1 | Presented instruction executes and writes back |
| defer_o | output | 1 | Presented instruction is parked in the queue |
| ckpt_take_o | output | 1 | Take register checkpoint |
| ckpt_release_o | output | 1 | Release checkpoint |
| ckpt_restore_o | output | 1 | Restore register file from checkpoint |
| squash_o | output | 1 | Flush pipeline |
| sb_discard_o | output | 1 | Discard store buffer contents |
| fetch_stall_o | output | 1 | Hold fetch |
| rally_valid_o | output | 1 | A parked entry is issued this cycle |
| rally_cls_o | output | CLS_W | Issued entry opcode class |
| rally_rs1_o | output | REG_W | Issued entry first source |
| rally_rs2_o | output | REG_W | Issued entry second source |
| rally_rd_o | output | REG_W | Issued entry destination |
| rally_wr_o | output | 1 | Issued entry writes destination |
| rally_opv_o | output | OPV_W | Issued entry saved operand value |

## Verification
The assertions rely on the environment in several ways. `flush_i` matters only in rally mode. `pipe_empty_i` is not raised in a drain cycle that also presents an instruction. No instruction is presented once rally mode is reached, since fetch is held. The stimulus drives every event at a negative edge and respects each of these limits. It presents instructions only in normal, advance and drain cycles, and raises the pipeline-empty flag on its own idle cycle. Because of that, the reference model never has to settle a drain-end cycle that also parks an instruction.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  parameter int unsigned NREG  = 32;
  parameter int unsigned CLS_W = 3;
  parameter int unsigned OPV_W = 16;
  localparam int unsigned REG_W = $clog2(NREG);

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ADVANCE = 2'd1,
    MODE_DRAIN   = 2'd2,
    MODE_RALLY   = 2'd3
  } mode_e;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             wr;
    logic [OPV_W-1:0] opv;
  } slice_t;
endpackage

// File: rtl/mtp_poison_file.sv
module mtp_poison_file
  import mtp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             clear_all_i,
  output logic             src_hit_o
);
  logic [NREG-1:0] taint_q;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               taint_q[g] <= 1'b0;
      else if (clear_all_i)                      taint_q[g] <= 1'b0;
      else if (set_i && rd_i == REG_W'(g))       taint_q[g] <= 1'b1;
      else if (clr_i && rd_i == REG_W'(g))       taint_q[g] <= 1'b0;
    end
  end

  assign src_hit_o = taint_q[rs1_i] | taint_q[rs2_i];
endmodule

// File: rtl/mtp_slice_fifo.sv
module mtp_slice_fifo
  import mtp_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  logic   pop_i,
  input  logic   flush_i,
  input  slice_t din_i,
  output slice_t dout_o,
  output logic   full_o,
  output logic   empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  slice_t           mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i && !full_o) wptr_q <= nxt(wptr_q);
      if (pop_i && !empty_o) rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i && !full_o) - CNT_W'(pop_i && !empty_o);
    end
  end

  assign dout_o  = mem_q[rptr_q];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/mtp_mode_ctrl.sv
module mtp_mode_ctrl
  import mtp_pkg::*;
#(
  parameter int unsigned SLICE_DEPTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_valid_i,
  input  logic             insn_miss_i,
  input  logic [CLS_W-1:0] insn_cls_i,
  input  logic [REG_W-1:0] insn_rs1_i,
  input  logic [REG_W-1:0] insn_rs2_i,
  input  logic [REG_W-1:0] insn_rd_i,
  input  logic             insn_wr_i,
  input  logic [OPV_W-1:0] insn_opv_i,
  input  logic             miss_ret_i,
  input  logic             pipe_empty_i,
  input  logic             sb_full_i,
  input  logic             flush_i,
  output logic [1:0]       mode_o,
  output logic             fallback_o,
  output logic             exec_o,
  output logic             defer_o,
  output logic             ckpt_take_o,
  output logic             ckpt_release_o,
  output logic             ckpt_restore_o,
  output logic             squash_o,
  output logic             sb_discard_o,
  output logic             fetch_stall_o,
  output logic             rally_valid_o,
  output logic [CLS_W-1:0] rally_cls_o,
  output logic [REG_W-1:0] rally_rs1_o,
  output logic [REG_W-1:0] rally_rs2_o,
  output logic [REG_W-1:0] rally_rd_o,
  output logic             rally_wr_o,
  output logic [OPV_W-1:0] rally_opv_o
);
  mode_e  mode_q, mode_d;
  logic   fb_q, fb_d;
  logic   src_hit, dep;
  logic   t_set, t_clr, t_clear_all;
  logic   push, pop, q_flush, q_full, q_empty;
  slice_t ent_in, ent_out;

  assign dep    = src_hit | insn_miss_i;
  assign ent_in = '{cls: insn_cls_i, rs1: insn_rs1_i, rs2: insn_rs2_i,
                    rd: insn_rd_i, wr: insn_wr_i, opv: insn_opv_i};

  always_comb begin
    mode_d = mode_q;
    fb_d   = fb_q;
    exec_o = 1'b0;  defer_o = 1'b0;
    ckpt_take_o = 1'b0;  ckpt_release_o = 1'b0;  ckpt_restore_o = 1'b0;
    squash_o = 1'b0;  sb_discard_o = 1'b0;  fetch_stall_o = 1'b0;
    rally_valid_o = 1'b0;
    t_set = 1'b0;  t_clr = 1'b0;  t_clear_all = 1'b0;
    push = 1'b0;  q_flush = 1'b0;
    unique case (mode_q)
      MODE_NORMAL: begin
        if (insn_valid_i && insn_miss_i) begin
          ckpt_take_o = 1'b1;
          defer_o     = 1'b1;
          push        = 1'b1;
          t_set       = insn_wr_i;
          mode_d      = MODE_ADVANCE;
        end else begin
          exec_o = insn_valid_i;
        end
      end
      MODE_ADVANCE, MODE_DRAIN: begin
        if (insn_valid_i) begin
          if (dep) begin
            t_set = insn_wr_i;
            if (!fb_q) begin
              if (q_full) fb_d = 1'b1;
              else begin push = 1'b1; defer_o = 1'b1; end
            end
          end else begin
            exec_o = 1'b1;
            t_clr  = insn_wr_i;
          end
        end
        if (sb_full_i) fb_d = 1'b1;
        if (mode_q == MODE_ADVANCE && miss_ret_i) mode_d = MODE_DRAIN;
        if (mode_q == MODE_DRAIN) begin
          fetch_stall_o = 1'b1;
          if (pipe_empty_i) begin
            if (fb_q) begin
              ckpt_restore_o = 1'b1;  squash_o = 1'b1;  sb_discard_o = 1'b1;
              q_flush = 1'b1;  t_clear_all = 1'b1;
              fb_d = 1'b0;  mode_d = MODE_NORMAL;
            end else begin
              mode_d = MODE_RALLY;
            end
          end
        end
      end
      MODE_RALLY: begin
        fetch_stall_o = !q_empty;
        rally_valid_o = !q_empty && !flush_i;
        if (flush_i) begin
          ckpt_restore_o = 1'b1;  squash_o = 1'b1;  sb_discard_o = 1'b1;
          q_flush = 1'b1;  t_clear_all = 1'b1;
          fb_d = 1'b0;  mode_d = MODE_NORMAL;
        end else if (q_empty && pipe_empty_i) begin
          ckpt_release_o = 1'b1;
          t_clear_all = 1'b1;
          fb_d = 1'b0;  mode_d = MODE_NORMAL;
        end
      end
      default: mode_d = MODE_NORMAL;
    endcase
  end

  assign pop = rally_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      fb_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      fb_q   <= fb_d;
    end
  end

  mtp_poison_file u_taint (
    .clk_i, .rst_ni,
    .rs1_i(insn_rs1_i), .rs2_i(insn_rs2_i), .rd_i(insn_rd_i),
    .set_i(t_set), .clr_i(t_clr), .clear_all_i(t_clear_all),
    .src_hit_o(src_hit)
  );

  mtp_slice_fifo #(.DEPTH(SLICE_DEPTH)) u_slice (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .flush_i(q_flush),
    .din_i(ent_in), .dout_o(ent_out),
    .full_o(q_full), .empty_o(q_empty)
  );

  assign mode_o      = mode_q;
  assign fallback_o  = fb_q;
  assign rally_cls_o = ent_out.cls;
  assign rally_rs1_o = ent_out.rs1;
  assign rally_rs2_o = ent_out.rs2;
  assign rally_rd_o  = ent_out.rd;
  assign rally_wr_o  = ent_out.wr;
  assign rally_opv_o = ent_out.opv;
endmodule

// File: rtl/mtp_mode_ctrl_chk.sv
module mtp_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       fallback_o,
  input logic       exec_o,
  input logic       defer_o,
  input logic       ckpt_take_o,
  input logic       ckpt_release_o,
  input logic       ckpt_restore_o,
  input logic       squash_o,
  input logic       sb_discard_o,
  input logic       fetch_stall_o,
  input logic       rally_valid_o
);
  p_take_enters_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_take_o |=> mode_o == 2'd1);
  p_exec_defer_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_o && defer_o));
  p_drain_stalls_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |-> fetch_stall_o);
  p_rally_issue_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rally_valid_o |-> mode_o == 2'd3);
  p_release_to_normal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_release_o |=> mode_o == 2'd0 && !fallback_o);
  p_restore_bundle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_restore_o |-> squash_o && sb_discard_o && !rally_valid_o);
  p_restore_to_normal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_restore_o |=> mode_o == 2'd0 && !fallback_o);
  p_fallback_no_defer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o |-> !defer_o);
  p_fallback_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fallback_o && mode_o == 2'd1) |=> fallback_o);
  p_single_ckpt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd0 |-> !ckpt_take_o);
endmodule

bind mtp_mode_ctrl mtp_mode_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .fallback_o(fallback_o),
  .exec_o(exec_o), .defer_o(defer_o), .ckpt_take_o(ckpt_take_o),
  .ckpt_release_o(ckpt_release_o), .ckpt_restore_o(ckpt_restore_o),
  .squash_o(squash_o), .sb_discard_o(sb_discard_o),
  .fetch_stall_o(fetch_stall_o), .rally_valid_o(rally_valid_o)
);

// File: tb/mtp_mode_ctrl_tb.sv
`timescale 1ns/1ps
module mtp_mode_ctrl_tb;
  import mtp_pkg::*;
  localparam int DEPTH = 128;
  localparam int EW = CLS_W + 3*REG_W + 1 + OPV_W;

  logic clk = 0, rst_ni = 0;
  logic insn_valid_i = 0, insn_miss_i = 0, insn_wr_i = 0;
  logic [CLS_W-1:0] insn_cls_i = '0;
  logic [REG_W-1:0] insn_rs1_i = '0, insn_rs2_i = '0, insn_rd_i = '0;
  logic [OPV_W-1:0] insn_opv_i = '0;
  logic miss_ret_i = 0, pipe_empty_i = 0, sb_full_i = 0, flush_i = 0;
  logic [1:0] mode_o;
  logic fallback_o, exec_o, defer_o, ckpt_take_o, ckpt_release_o, ckpt_restore_o;
  logic squash_o, sb_discard_o, fetch_stall_o, rally_valid_o, rally_wr_o;
  logic [CLS_W-1:0] rally_cls_o;
  logic [REG_W-1:0] rally_rs1_o, rally_rs2_o, rally_rd_o;
  logic [OPV_W-1:0] rally_opv_o;

  always #4 clk = ~clk;

  mtp_mode_ctrl #(.SLICE_DEPTH(DEPTH)) u_dut (.clk_i(clk), .*);

  int checks = 0, fails = 0, opv_ctr = 1;
  int md = 0;
  bit fb = 0;
  bit pz [NREG];
  logic [EW-1:0] q [$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit ms, int s1, int s2, int d,
                      bit mr, bit pe, bit sf, bit fl);
    bit e_exec = 0, e_def = 0, e_take = 0, e_rel = 0, e_rest = 0, e_stall = 0, e_rv = 0;
    bit do_push = 0, do_pop = 0, do_clr = 0, do_set = 0, do_unset = 0, dep;
    int n_md = md;
    bit n_fb = fb;
    logic [EW-1:0] ent;
    insn_valid_i = v; insn_miss_i = ms; insn_wr_i = 1'b1;
    insn_rs1_i = REG_W'(s1); insn_rs2_i = REG_W'(s2); insn_rd_i = REG_W'(d);
    insn_cls_i = CLS_W'(s1 + d); insn_opv_i = OPV_W'(opv_ctr * 37);
    opv_ctr++;
    miss_ret_i = mr; pipe_empty_i = pe; sb_full_i = sf; flush_i = fl;
    ent = {insn_cls_i, insn_rs1_i, insn_rs2_i, insn_rd_i, 1'b1, insn_opv_i};
    dep = pz[s1] | pz[s2] | ms;
    #2;
    case (md)
      0: if (v && ms) begin e_take = 1; e_def = 1; do_push = 1; do_set = 1; n_md = 1; end
         else if (v) e_exec = 1;
      1, 2: begin
        if (v) begin
          if (dep) begin
            do_set = 1;
            if (!fb) begin
              if (q.size() >= DEPTH) n_fb = 1;
              else begin do_push = 1; e_def = 1; end
            end
          end else begin e_exec = 1; do_unset = 1; end
        end
        if (sf) n_fb = 1;
        if (md == 1 && mr) n_md = 2;
        if (md == 2) begin
          e_stall = 1;
          if (pe) begin
            if (fb) begin e_rest = 1; do_clr = 1; n_fb = 0; n_md = 0; end
            else n_md = 3;
          end
        end
      end
      default: begin
        e_stall = q.size() > 0;
        e_rv = (q.size() > 0) && !fl;
        if (fl) begin e_rest = 1; do_clr = 1; n_fb = 0; n_md = 0; end
        else if (q.size() == 0 && pe) begin e_rel = 1; do_clr = 1; n_fb = 0; n_md = 0; end
        do_pop = e_rv;
      end
    endcase
    chk(tag, "ctl{exec,defer,take,rel,rest,squash,disc,stall,rv,fb,mode}",
        {exec_o, defer_o, ckpt_take_o, ckpt_release_o, ckpt_restore_o, squash_o,
         sb_discard_o, fetch_stall_o, rally_valid_o, fallback_o, mode_o},
        {e_exec, e_def, e_take, e_rel, e_rest, e_rest, e_rest, e_stall, e_rv, fb, 2'(md)});
    if (e_rv)
      chk(tag, "rally_entry",
          {rally_cls_o, rally_rs1_o, rally_rs2_o, rally_rd_o, rally_wr_o, rally_opv_o}, q[0]);
    @(posedge clk);
    if (do_set) pz[d] = 1;
    if (do_unset) pz[d] = 0;
    if (do_push) q.push_back(ent);
    if (do_pop) void'(q.pop_front());
    if (do_clr) begin q.delete(); foreach (pz[i]) pz[i] = 0; end
    md = n_md; fb = n_fb;
    @(negedge clk);
  endtask

  task automatic idle(string tag, bit pe);
    step(tag, 0, 0, 0, 0, 0, 0, pe, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (pz[i]) pz[i] = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset{mode,fb,stall,rv,take,rel,rest}",
        {mode_o, fallback_o, fetch_stall_o, rally_valid_o, ckpt_take_o, ckpt_release_o, ckpt_restore_o},
        '0);
    rst_ni = 1;
    @(negedge clk);
    step("R11", 1, 0, 1, 2, 3, 0, 0, 0, 0);
    step("R1",  1, 0, 4, 5, 6, 0, 0, 0, 0);
    step("R1",  1, 1, 1, 0, 2, 0, 0, 0, 0);   // miss, r2 tainted
    step("R2",  1, 0, 2, 0, 3, 0, 0, 0, 0);   // dep, r3 tainted
    step("R3",  1, 0, 5, 6, 3, 0, 0, 0, 0);   // clean, untaints r3
    step("R3",  1, 0, 3, 7, 8, 0, 0, 0, 0);   // r3 clean now: exec
    step("R10", 1, 1, 7, 0, 4, 0, 0, 0, 0);   // second miss
    step("R2",  1, 0, 9, 4, 6, 0, 0, 0, 0);   // dep via rs2
    step("R4",  0, 0, 0, 0, 0, 1, 0, 0, 0);   // miss returns
    step("R4",  1, 0, 6, 0, 10, 0, 0, 0, 0);  // in-flight dep during drain
    step("R4",  1, 0, 11, 0, 12, 0, 0, 0, 0); // in-flight clean during drain
    idle("R4", 1);                            // drain done -> rally
    for (int i = 0; i < 5; i++) idle("R5", 0);
    idle("R5", 0);                            // empty, fetch released
    idle("R6", 1);                            // release
    step("R6",  1, 1, 0, 0, 9, 0, 0, 0, 0);
    step("R6",  1, 0, 3, 2, 13, 0, 0, 0, 0);  // taint cleared: exec
    step("R7",  1, 0, 9, 0, 14, 0, 0, 0, 0);
    step("R7",  0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle("R7", 1);
    idle("R7", 0);
    step("R7",  0, 0, 0, 0, 0, 0, 0, 0, 1);   // flush during rally
    step("R7",  1, 0, 9, 14, 15, 0, 0, 0, 0); // normal, exec
    step("R8",  1, 1, 0, 0, 20, 0, 0, 0, 0);
    step("R8",  1, 0, 1, 2, 5, 0, 0, 1, 0);   // store buffer full
    step("R8",  1, 0, 20, 0, 21, 0, 0, 0, 0); // dep, not parked
    step("R8",  1, 0, 3, 0, 22, 1, 0, 0, 0);
    idle("R8", 0);
    idle("R8", 1);                            // restore at drain end
    idle("R8", 0);
    step("R9",  1, 1, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step("R9", 1, 0, 1, 0, 2 + (i % 8), 0, 0, 0, 0);
    step("R9",  1, 0, 1, 0, 30, 0, 0, 0, 0);  // 129th -> fallback
    step("R9",  1, 0, 30, 0, 31, 1, 0, 0, 0);
    idle("R9", 1);
    idle("R9", 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule